// File: doc/BRIEF.md
# Overload Hiccup Fault Controller

This block supervises the overcurrent response of a switching converter. It watches two logic flags from the analog front end: one pulses or holds high while the power stage is in current limit, and one is high while feedback sits below 70% of the active reference. When both flags stay high together for a qualification time, the block forces both power switches off. It also asks the compensation node and the reference/soft-start node to be pulled low. It holds that state for a fixed number of switching-clock periods and then allows a restart window of its own length. At the end of the restart window it either returns to normal operation or goes back into the off state.

Window lengths are counted in ticks of the free-running switching clock (`tick_i`). The qualification time is counted in system clocks. Current-limit qualification is blanked for a fixed number of ticks after enable, so inrush at start-up cannot trigger a hiccup. Dropping the enable returns the block to idle on the next clock. A sticky flag shows that at least one hiccup has happened since the last enable.

Top module: `hiccup_ctrl`

## Requirements
- R1: In normal operation the block enters hiccup only after `ilim_i` and `fb_low_i` have both been high on QUAL_CYCLES consecutive rising clock edges, with the default QUAL_CYCLES = 72. A single edge on which either flag is low restarts the count from zero.
- R2: While in hiccup, `sw_off_o`, `comp_pull_o` and `ref_pull_o` are all 1 and `retry_o` is 0.
- R3: The hiccup off state lasts exactly OFF_TICKS ticks (default 896), counting one per clock edge on which `tick_i` is high. After that the block moves to the retry window.
- R4: The retry window lasts RETRY_TICKS ticks (default 112). During it `retry_o` is 1 and the other three outputs are 0. Current-limit and feedback flags inside the window do not start a hiccup.
- R5: On the final tick of the retry window, if `ilim_i` is 1 the block goes back to the off state. If `ilim_i` is 0 it resumes normal operation with all four outputs at 0.
- R6: After enable rises, qualification is held off for BLANK_TICKS ticks (default 112). The block reaches normal operation on the 113th clock edge after enable is seen high (with a tick on every clock). Qualification counting starts from zero only then.
- R7: When `en_i` is 0 at a clock edge, the block is idle after that edge. All four outputs are 0 and every counter is cleared, so a later enable starts a fresh blanking window.
- R8: `hiccup_seen_o` becomes 1 in the same cycle the off state is entered. It keeps that value while disabled and clears on the first clock edge at which enable is seen high after idle.
- R9: Window lengths count ticks, not clocks. With one tick every four clocks, the off state lasts 4*OFF_TICKS clocks.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| tick_i | input | 1 | One-clock strobe per switching period |
| ilim_i | input | 1 | Current-limit event flag |
| fb_low_i | input | 1 | Feedback below 70% of reference |
| sw_off_o | output | 1 | Force both power switches off |
| comp_pull_o | output | 1 | Pull compensation node low |
| ref_pull_o | output | 1 | Pull reference/soft-start node low |
| retry_o | output | 1 | Restart window active |
| hiccup_seen_o | output | 1 | Sticky: a hiccup occurred since enable |

## Verification
A wrong state in the sequencer shows up directly at the ports, because every output is decoded from the registered state. An off-by-one in a window counter moves the fall of `sw_off_o` or `retry_o` by one tick, and the bench samples exactly one clock either side of each expected boundary. A qualification counter that fails to restart, or that counts during blanking, makes `sw_off_o` rise early, at a clock the bench has already marked as too soon. A wrong retry decision shows up one clock after the window closes, as `sw_off_o` at the wrong level.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RUN,
    ST_OFF,
    ST_RETRY
  } hic_state_e;
endpackage

// File: rtl/hiccup_qual.sv
module hiccup_qual #(
  parameter int QUAL_CYCLES = 72,
  localparam int W = $clog2(QUAL_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ilim_i,
  input  logic fb_low_i,
  output logic done_o
);
  logic         cond;
  logic [W-1:0] cnt_q;

  assign cond   = arm_i && ilim_i && fb_low_i;
  assign done_o = cond && (cnt_q == W'(QUAL_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!cond)  cnt_q <= '0;
    else if (done_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // a completed qualification needs the condition on the previous edge too
  a_r1_needs_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(arm_i && ilim_i && fb_low_i));

  a_r1_restart_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond |=> !done_o);
endmodule

// File: rtl/hiccup_window.sv
module hiccup_window #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = active_i && tick_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !active_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  a_r3_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q <= last_i));

  a_r9_holds_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
  import hiccup_pkg::*;
#(
  parameter int QUAL_CYCLES = 72,
  parameter int OFF_TICKS   = 896,
  parameter int RETRY_TICKS = 112,
  parameter int BLANK_TICKS = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic ilim_i,
  input  logic fb_low_i,
  output logic sw_off_o,
  output logic comp_pull_o,
  output logic ref_pull_o,
  output logic retry_o,
  output logic hiccup_seen_o
);
  localparam int MAX_A = (OFF_TICKS > RETRY_TICKS) ? OFF_TICKS : RETRY_TICKS;
  localparam int MAX_T = (MAX_A > BLANK_TICKS) ? MAX_A : BLANK_TICKS;
  localparam int CNT_W = $clog2(MAX_T);

  hic_state_e       state_q, state_d;
  logic             qual_done, win_done, win_active, win_clr, seen_q;
  logic [CNT_W-1:0] win_last;

  hiccup_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (state_q == ST_RUN),
    .ilim_i   (ilim_i),
    .fb_low_i (fb_low_i),
    .done_o   (qual_done)
  );

  always_comb begin
    unique case (state_q)
      ST_START: win_last = CNT_W'(BLANK_TICKS - 1);
      ST_OFF:   win_last = CNT_W'(OFF_TICKS - 1);
      ST_RETRY: win_last = CNT_W'(RETRY_TICKS - 1);
      default:  win_last = '0;
    endcase
  end

  assign win_active = (state_q == ST_START) || (state_q == ST_OFF) || (state_q == ST_RETRY);
  assign win_clr    = (state_d != state_q);

  hiccup_window #(.CNT_W(CNT_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (win_active),
    .clr_i    (win_clr),
    .tick_i   (tick_i),
    .last_i   (win_last),
    .done_o   (win_done)
  );

  always_comb begin
    state_d = state_q;
    if (!en_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_START;
        ST_START: if (win_done)  state_d = ST_RUN;
        ST_RUN:   if (qual_done) state_d = ST_OFF;
        ST_OFF:   if (win_done)  state_d = ST_RETRY;
        ST_RETRY: if (win_done)  state_d = ilim_i ? ST_OFF : ST_RUN;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && state_d == ST_START)   seen_q <= 1'b0;
      else if (state_d == ST_OFF && state_q != ST_OFF) seen_q <= 1'b1;
    end
  end

  assign sw_off_o      = (state_q == ST_OFF);
  assign comp_pull_o   = (state_q == ST_OFF);
  assign ref_pull_o    = (state_q == ST_OFF);
  assign retry_o       = (state_q == ST_RETRY);
  assign hiccup_seen_o = seen_q;

  a_r1_off_entry_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_off_o) |-> ($past(qual_done) || $past(retry_o && ilim_i)));

  a_r5_retry_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(retry_o) && $past(en_i)) |-> (sw_off_o == $past(ilim_i)));

  a_r7_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sw_off_o && !retry_o));

  a_r8_seen_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_off_o) |-> hiccup_seen_o);

  a_r4_retry_follows_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retry_o) |-> $past(sw_off_o));
endmodule

// File: tb/hiccup_ctrl_bench.sv
module hiccup_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL  = 72;
  localparam int OFFT  = 896;
  localparam int RETRT = 112;
  localparam int BLANK = 112;

  typedef struct packed {
    logic        ilim;
    logic        fbl;
    logic [15:0] clocks;
    logic        exp_off;
  } vec_t;

  // R1 qualification patterns applied in normal operation
  localparam vec_t VECS [4] = '{
    '{1'b1, 1'b1, 16'd71,  1'b0},
    '{1'b1, 1'b0, 16'd200, 1'b0},
    '{1'b0, 1'b1, 16'd200, 1'b0},
    '{1'b1, 1'b1, 16'd72,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0, en_i = 1'b0, tick_i = 1'b1, ilim_i = 1'b0, fb_low_i = 1'b0;
  logic sw_off_o, comp_pull_o, ref_pull_o, retry_o, hiccup_seen_o;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_ctrl u_hiccup_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick_i),
    .ilim_i(ilim_i), .fb_low_i(fb_low_i),
    .sw_off_o(sw_off_o), .comp_pull_o(comp_pull_o), .ref_pull_o(ref_pull_o),
    .retry_o(retry_o), .hiccup_seen_o(hiccup_seen_o)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_outs(string req, logic off, logic rt);
    chk(req, "sw_off_o", sw_off_o, off);
    chk(req, "comp_pull_o", comp_pull_o, off);
    chk(req, "ref_pull_o", ref_pull_o, off);
    chk(req, "retry_o", retry_o, rt);
  endtask

  task automatic restart();
    en_i = 1'b0; ilim_i = 1'b0; fb_low_i = 1'b0; tick_i = 1'b1;
    step(1);
    en_i = 1'b1;
    step(BLANK + 1);
  endtask

  task automatic tick_steps(int n, int div);
    repeat (n) begin
      tick_i = 1'b0; step(div - 1);
      tick_i = 1'b1; step(1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    chk_outs("R10", 1'b0, 1'b0);
    chk("R10", "hiccup_seen_o", hiccup_seen_o, 1'b0);
    rst_ni = 1'b1;
    step(1);

    for (int i = 0; i < 4; i++) begin
      restart();
      ilim_i = VECS[i].ilim; fb_low_i = VECS[i].fbl;
      step(int'(VECS[i].clocks));
      chk("R1", $sformatf("vector %0d sw_off_o", i), sw_off_o, VECS[i].exp_off);
    end

    // R1: a one-edge drop restarts the count
    restart();
    ilim_i = 1'b1; fb_low_i = 1'b1; step(50);
    fb_low_i = 1'b0; step(1);
    fb_low_i = 1'b1; step(QUAL - 1);
    chk("R1", "restart after drop", sw_off_o, 1'b0);
    step(1);
    chk_outs("R2", 1'b1, 1'b0);
    chk("R8", "seen on entry", hiccup_seen_o, 1'b1);
    ilim_i = 1'b0; fb_low_i = 1'b0;

    // R3 off length
    step(OFFT - 1);
    chk_outs("R3", 1'b1, 1'b0);
    step(1);
    chk_outs("R3", 1'b0, 1'b1);

    // R4 retry ignores flags until its end, R5 re-entry
    ilim_i = 1'b1; fb_low_i = 1'b1;
    step(RETRT - 1);
    chk_outs("R4", 1'b0, 1'b1);
    step(1);
    chk_outs("R5", 1'b1, 1'b0);

    // R5 resume
    ilim_i = 1'b0; fb_low_i = 1'b0;
    step(OFFT);
    chk("R4", "retry after off", retry_o, 1'b1);
    step(RETRT);
    chk_outs("R5", 1'b0, 1'b0);

    // R1: fresh qualification after resume
    ilim_i = 1'b1; fb_low_i = 1'b1;
    step(QUAL - 1);
    chk("R1", "requal early", sw_off_o, 1'b0);
    step(1);
    chk("R1", "requal fires", sw_off_o, 1'b1);

    // R7 disable from off, R8 sticky across disable
    en_i = 1'b0; step(1);
    chk_outs("R7", 1'b0, 1'b0);
    chk("R8", "seen kept while disabled", hiccup_seen_o, 1'b1);

    // R6 blanking with flags held from enable, R8 clear
    en_i = 1'b1; step(1);
    chk("R8", "seen cleared on enable", hiccup_seen_o, 1'b0);
    step(BLANK + QUAL - 1);
    chk("R6", "no hiccup during blanking", sw_off_o, 1'b0);
    step(1);
    chk("R6", "hiccup after blanking", sw_off_o, 1'b1);
    ilim_i = 1'b0; fb_low_i = 1'b0;

    // R9 ticks every fourth clock
    tick_steps(OFFT - 1, 4);
    chk("R9", "off held at 4x", sw_off_o, 1'b1);
    tick_steps(1, 4);
    chk("R9", "retry after 4x off", retry_o, 1'b1);
    tick_i = 1'b1;
    step(RETRT);
    chk_outs("R9", 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule